// File: doc/BRIEF.md
# SMBus Host Register Front-End

This block is the software-visible face of a bus-mapped SMBus host controller. A byte-wide register port with eight offsets holds the target address byte, the transaction type, the command byte and two data bytes. It hands these to a separate protocol engine that does the bit-level signalling. When software writes the start offset, the block sends the engine a single-cycle launch pulse. The engine's completion and error reports are caught in a status register, and software clears those flags by writing ones to them.

Block transfers use a 32-byte buffer that software reaches through a single port offset. Each access to that port moves an internal pointer on by one. A bit in the control register wipes both the buffer and the pointer. The engine sees the buffer through its own indexed port. It can also load both data bytes at once, for example to return a received byte count or a received word.

Top module: `smbh_regs`

## Requirements
- R1: After reset, go, timeout_req and abort_req are low, offsets 1, 3, 4, 5 and 7 read 0x00, and status (offset 0) reads 0x04.
- R2: Offsets 3 (address), 4 (data A), 5 (data B) and 7 (command) read back the last byte written, and each drives its output port. A write to offset 1 stores bits 6:4 as the transfer type on xfer_type. Offset 1 reads the type in bits 6:4 with all other bits 0. The type codes are 0 quick, 1 send/receive byte, 2 write/read byte, 3 write/read word and 4 block.
- R3: A write to offset 2 with any data value, while not busy, raises go for exactly the one cycle after the write. From that cycle on, status bit 3 (busy) is 1 and bit 2 (idle) is 0.
- R4: A write to offset 2 while busy produces no go pulse.
- R5: An eng_done cycle does four things in the same edge. It sets status bit 4 (complete). It ORs eng_err_term into bit 7, eng_err_coll into bit 6 and eng_err_dev into bit 5. It clears busy, and it sets idle.
- R6: Writing offset 0 clears each of bits 7:4 whose data bit is 1 and leaves the other event bits alone. Bits 3:0 are not changed by writes. If an engine event and a clear arrive in the same cycle, the event wins.
- R7: Each write to offset 6 stores the byte at the buffer pointer and advances the pointer. Each read of offset 6 returns the byte at the pointer and advances it. The pointer wraps from 31 to 0.
- R8: Writing offset 1 with bit 7 set zeroes all 32 buffer bytes and the pointer. Bit 3 gives a one-cycle timeout_req pulse and bit 2 a one-cycle abort_req pulse. Bits 7, 3 and 2 are not stored and read back 0.
- R9: eng_data_we loads data A and data B from the engine. eng_buf_we writes buffer entry eng_buf_idx, and eng_buf_rdata returns entry eng_buf_idx.
- R10: Status bits 1 and 0 show eng_slv_sts and eng_slv_busy as they are in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances the block pointer on offset 6) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| go | output | 1 | One-cycle launch pulse to the engine |
| xfer_type | output | 3 | Transfer type code |
| tgt_addr | output | 8 | Target address byte (bit 0 = direction) |
| cmd_byte | output | 8 | Command byte |
| data_a | output | 8 | Data A / block count |
| data_b | output | 8 | Data B |
| timeout_req | output | 1 | One-cycle timeout request |
| abort_req | output | 1 | One-cycle abort request |
| eng_done | input | 1 | Engine completion event |
| eng_err_term | input | 1 | Transaction terminated |
| eng_err_coll | input | 1 | Bus collision / no acknowledge |
| eng_err_dev | input | 1 | Device error |
| eng_slv_sts | input | 1 | Live host/slave status |
| eng_slv_busy | input | 1 | Live host/slave busy |
| eng_data_we | input | 1 | Engine load of data A and B |
| eng_data_a | input | 8 | Engine value for data A |
| eng_data_b | input | 8 | Engine value for data B |
| eng_buf_we | input | 1 | Engine buffer write |
| eng_buf_idx | input | 5 | Engine buffer index |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Buffer entry at eng_buf_idx |

## Verification
A stuck or miscounted block pointer shows up on the very next port access: the byte that comes back is off by one position, or the wrap from 31 to 0 returns the wrong entry. If the busy flag is wrong, a second start write produces an extra go pulse, or a legal start produces none, one cycle after the write. Mistakes in event latching or clearing show at status offset 0 on the cycle right after the engine event or the clearing write. This includes the case where an event and a clear land in the same cycle.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam logic [2:0] OFS_STAT  = 3'd0;
  localparam logic [2:0] OFS_CTRL  = 3'd1;
  localparam logic [2:0] OFS_START = 3'd2;
  localparam logic [2:0] OFS_ADDR  = 3'd3;
  localparam logic [2:0] OFS_DA    = 3'd4;
  localparam logic [2:0] OFS_DB    = 3'd5;
  localparam logic [2:0] OFS_BLK   = 3'd6;
  localparam logic [2:0] OFS_CMD   = 3'd7;

  // control byte bit positions
  localparam int unsigned CTL_BUFCLR = 7;
  localparam int unsigned CTL_TYPE_LO = 4;
  localparam int unsigned CTL_TMO = 3;
  localparam int unsigned CTL_ABT = 2;

  // event vector layout inside the status block: {term, coll, dev, complete}
  localparam int unsigned EV_W = 4;

  typedef enum logic [2:0] {
    XT_QUICK = 3'd0,
    XT_BYTE  = 3'd1,
    XT_RWB   = 3'd2,
    XT_WORD  = 3'd3,
    XT_BLOCK = 3'd4
  } xfer_e;
endpackage

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          eng_we,
  input  logic [PW-1:0] eng_idx,
  input  logic [DW-1:0] eng_wdata,
  output logic [DW-1:0] eng_rdata
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic [PW-1:0] ptr_q, ptr_d;
  logic          step;

  assign step      = bus_we | bus_re;
  assign bus_rdata = mem_q[ptr_q];
  assign eng_rdata = mem_q[eng_idx];

  always_comb begin
    ptr_d = ptr_q;
    if (clr) begin
      ptr_d = '0;
    end else if (step) begin
      ptr_d = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
    end
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_d[i] = '0;
      end
    end else begin
      if (eng_we) mem_d[eng_idx] = eng_wdata;
      if (bus_we) mem_d[ptr_q]   = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (clr || step) begin
      ptr_q <= ptr_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[g] <= '0;
        end else if (clr || eng_we || bus_we) begin
          mem_q[g] <= mem_d[g];
        end
      end
    end
  endgenerate

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && ptr_q != PW'(DEPTH - 1)) |=> ptr_q == $past(ptr_q) + 1'b1);
  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && ptr_q == PW'(DEPTH - 1)) |=> ptr_q == '0);
  assert_clr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_q == '0 && bus_rdata == '0));
endmodule

// File: rtl/smbh_status.sv
module smbh_status
  import smbh_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            eng_done,
  input  logic [2:0]      eng_err,
  input  logic            w1c_we,
  input  logic [EV_W-1:0] w1c_mask,
  output logic [EV_W-1:0] ev,
  output logic            busy
);
  logic [EV_W-1:0] ev_q, ev_d;
  logic            busy_q, busy_d;

  always_comb begin
    ev_d = ev_q;
    if (w1c_we)   ev_d = ev_d & ~w1c_mask;
    if (eng_done) ev_d = ev_d | {eng_err, 1'b1};
  end

  always_comb begin
    busy_d = busy_q;
    if (eng_done)    busy_d = 1'b0;
    else if (launch) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      if (w1c_we || eng_done) ev_q <= ev_d;
      if (eng_done || launch) busy_q <= busy_d;
    end
  end

  assign ev   = ev_q;
  assign busy = busy_q;

  assert_done_sets_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (ev_q[0] && !busy_q));
  assert_done_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eng_err[2]) |=> ev_q[3]);
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_we && !eng_done) |=> ev_q == ($past(ev_q) & ~$past(w1c_mask)));
endmodule

// File: rtl/smbh_regs.sv
module smbh_regs
  import smbh_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned BUF_DEPTH = 32,
  localparam int unsigned IW       = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          go,
  output logic [2:0]    xfer_type,
  output logic [DW-1:0] tgt_addr,
  output logic [DW-1:0] cmd_byte,
  output logic [DW-1:0] data_a,
  output logic [DW-1:0] data_b,
  output logic          timeout_req,
  output logic          abort_req,
  input  logic          eng_done,
  input  logic          eng_err_term,
  input  logic          eng_err_coll,
  input  logic          eng_err_dev,
  input  logic          eng_slv_sts,
  input  logic          eng_slv_busy,
  input  logic          eng_data_we,
  input  logic [DW-1:0] eng_data_a,
  input  logic [DW-1:0] eng_data_b,
  input  logic          eng_buf_we,
  input  logic [IW-1:0] eng_buf_idx,
  input  logic [DW-1:0] eng_buf_wdata,
  output logic [DW-1:0] eng_buf_rdata
);
  // decoded strobes
  logic wr_stat, wr_ctrl, wr_start, wr_addr, wr_da, wr_db, wr_blk, wr_cmd, rd_blk;
  assign wr_stat  = bus_wr && bus_addr == OFS_STAT;
  assign wr_ctrl  = bus_wr && bus_addr == OFS_CTRL;
  assign wr_start = bus_wr && bus_addr == OFS_START;
  assign wr_addr  = bus_wr && bus_addr == OFS_ADDR;
  assign wr_da    = bus_wr && bus_addr == OFS_DA;
  assign wr_db    = bus_wr && bus_addr == OFS_DB;
  assign wr_blk   = bus_wr && bus_addr == OFS_BLK;
  assign wr_cmd   = bus_wr && bus_addr == OFS_CMD;
  assign rd_blk   = bus_rd && bus_addr == OFS_BLK;

  logic          busy;
  logic [EV_W-1:0] ev;
  logic [DW-1:0] blk_rdata;

  // control-side registers
  logic [2:0]    type_q, type_d;
  logic [DW-1:0] addr_q, addr_d, cmd_q, cmd_d, da_q, da_d, db_q, db_d;
  logic          go_q, go_d, tmo_q, tmo_d, abt_q, abt_d;

  always_comb begin
    type_d = type_q;
    addr_d = addr_q;
    cmd_d  = cmd_q;
    da_d   = da_q;
    db_d   = db_q;
    if (wr_ctrl) type_d = bus_wdata[CTL_TYPE_LO +: 3];
    if (wr_addr) addr_d = bus_wdata;
    if (wr_cmd)  cmd_d  = bus_wdata;
    if (eng_data_we) begin
      da_d = eng_data_a;
      db_d = eng_data_b;
    end
    if (wr_da) da_d = bus_wdata;
    if (wr_db) db_d = bus_wdata;
  end

  always_comb begin
    go_d  = wr_start && !busy;
    tmo_d = wr_ctrl && bus_wdata[CTL_TMO];
    abt_d = wr_ctrl && bus_wdata[CTL_ABT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      addr_q <= '0;
      cmd_q  <= '0;
      da_q   <= '0;
      db_q   <= '0;
    end else begin
      if (wr_ctrl)                 type_q <= type_d;
      if (wr_addr)                 addr_q <= addr_d;
      if (wr_cmd)                  cmd_q  <= cmd_d;
      if (wr_da || eng_data_we)    da_q   <= da_d;
      if (wr_db || eng_data_we)    db_q   <= db_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q  <= 1'b0;
      tmo_q <= 1'b0;
      abt_q <= 1'b0;
    end else begin
      go_q  <= go_d;
      tmo_q <= tmo_d;
      abt_q <= abt_d;
    end
  end

  smbh_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (go_d),
    .eng_done (eng_done),
    .eng_err  ({eng_err_term, eng_err_coll, eng_err_dev}),
    .w1c_we   (wr_stat),
    .w1c_mask (bus_wdata[DW-1 -: EV_W]),
    .ev       (ev),
    .busy     (busy)
  );

  smbh_blkbuf #(
    .DEPTH (BUF_DEPTH),
    .DW    (DW)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (wr_ctrl && bus_wdata[CTL_BUFCLR]),
    .bus_we    (wr_blk),
    .bus_re    (rd_blk),
    .bus_wdata (bus_wdata),
    .bus_rdata (blk_rdata),
    .eng_we    (eng_buf_we),
    .eng_idx   (eng_buf_idx),
    .eng_wdata (eng_buf_wdata),
    .eng_rdata (eng_buf_rdata)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_STAT: bus_rdata = {ev, busy, !busy, eng_slv_sts, eng_slv_busy};
      OFS_CTRL: bus_rdata = {1'b0, type_q, 4'b0000};
      OFS_ADDR: bus_rdata = addr_q;
      OFS_DA:   bus_rdata = da_q;
      OFS_DB:   bus_rdata = db_q;
      OFS_BLK:  bus_rdata = blk_rdata;
      OFS_CMD:  bus_rdata = cmd_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign go          = go_q;
  assign xfer_type   = type_q;
  assign tgt_addr    = addr_q;
  assign cmd_byte    = cmd_q;
  assign data_a      = da_q;
  assign data_b      = db_q;
  assign timeout_req = tmo_q;
  assign abort_req   = abt_q;

  assert_go_marks_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> busy);
  assert_go_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  assert_no_relaunch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !go);
endmodule

// File: tb/smbh_regs_bench.sv
`timescale 1ns/1ps
module smbh_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       go, timeout_req, abort_req;
  logic [2:0] xfer_type;
  logic [7:0] tgt_addr, cmd_byte, data_a, data_b;
  logic       eng_done = 1'b0, eng_err_term = 1'b0, eng_err_coll = 1'b0, eng_err_dev = 1'b0;
  logic       eng_slv_sts = 1'b0, eng_slv_busy = 1'b0;
  logic       eng_data_we = 1'b0;
  logic [7:0] eng_data_a = '0, eng_data_b = '0;
  logic       eng_buf_we = 1'b0;
  logic [4:0] eng_buf_idx = '0;
  logic [7:0] eng_buf_wdata = '0;
  logic [7:0] eng_buf_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  smbh_regs u_smbh_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .go(go), .xfer_type(xfer_type),
    .tgt_addr(tgt_addr), .cmd_byte(cmd_byte), .data_a(data_a), .data_b(data_b),
    .timeout_req(timeout_req), .abort_req(abort_req), .eng_done(eng_done),
    .eng_err_term(eng_err_term), .eng_err_coll(eng_err_coll), .eng_err_dev(eng_err_dev),
    .eng_slv_sts(eng_slv_sts), .eng_slv_busy(eng_slv_busy), .eng_data_we(eng_data_we),
    .eng_data_a(eng_data_a), .eng_data_b(eng_data_b), .eng_buf_we(eng_buf_we),
    .eng_buf_idx(eng_buf_idx), .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic done_evt(input logic [2:0] e);
    @(negedge clk);
    {eng_err_term, eng_err_coll, eng_err_dev} = e; eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0; {eng_err_term, eng_err_coll, eng_err_dev} = 3'b000;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 go", {7'd0, go}, 8'h00);
    check("R1 pulses", {6'd0, timeout_req, abort_req}, 8'h00);
    rd(3'd0, v); check("R1 status", v, 8'h04);
    rd(3'd1, v); check("R1 ctrl", v, 8'h00);
    rd(3'd3, v); check("R1 addr", v, 8'h00);
    rd(3'd4, v); check("R1 dataA", v, 8'h00);
    rd(3'd5, v); check("R1 dataB", v, 8'h00);
    rd(3'd7, v); check("R1 cmd", v, 8'h00);

    // R2 sweep of plain registers
    for (int k = 0; k < 256; k += 17) begin
      wr(3'd3, 8'(k));       wr(3'd4, 8'(k ^ 8'h5A));
      wr(3'd5, 8'(k ^ 8'hC3)); wr(3'd7, 8'(255 - k));
      rd(3'd3, v); check("R2 addr", v, 8'(k));
      check("R2 tgt_addr port", tgt_addr, 8'(k));
      rd(3'd4, v); check("R2 dataA", v, 8'(k ^ 8'h5A));
      rd(3'd5, v); check("R2 dataB", v, 8'(k ^ 8'hC3));
      rd(3'd7, v); check("R2 cmd", v, 8'(255 - k));
      check("R2 cmd port", cmd_byte, 8'(255 - k));
    end
    for (int t = 0; t < 8; t++) begin
      wr(3'd1, 8'(t << 4) | 8'h01);
      rd(3'd1, v); check("R2 type readback", v, 8'(t << 4));
      check("R2 xfer_type", {5'd0, xfer_type}, 8'(t));
    end

    // R10 live slave bits
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); {eng_slv_sts, eng_slv_busy} = 2'(s);
      rd(3'd0, v); check("R10 slave bits", v, 8'h04 | 8'(s));
    end
    @(negedge clk); {eng_slv_sts, eng_slv_busy} = 2'b00;

    // R3 launch, R4 relaunch ignored, R5 events
    for (int e = 0; e < 8; e++) begin
      wr(3'd2, 8'(e * 29));
      check("R3 go pulse", {7'd0, go}, 8'h01);
      @(negedge clk);
      check("R3 go single", {7'd0, go}, 8'h00);
      rd(3'd0, v); check("R3 busy status", v, 8'h08);
      wr(3'd2, 8'hFF);
      check("R4 no go while busy", {7'd0, go}, 8'h00);
      @(negedge clk);
      check("R4 no go later", {7'd0, go}, 8'h00);
      done_evt(3'(e));
      rd(3'd0, v); check("R5 done status", v, 8'(e << 5) | 8'h14);
      wr(3'd0, 8'hFF);
      rd(3'd0, v); check("R6 clear all", v, 8'h04);
    end

    // R6 partial clear and read-only low bits
    wr(3'd2, 8'h00);
    done_evt(3'b111);
    wr(3'd0, 8'h20);
    rd(3'd0, v); check("R6 partial clear", v, 8'hD4);
    wr(3'd0, 8'h0F);
    rd(3'd0, v); check("R6 low bits read-only", v, 8'hD4);
    wr(3'd0, 8'hFF);
    // event and clear in the same cycle
    wr(3'd2, 8'h00);
    @(negedge clk);
    bus_addr = 3'd0; bus_wdata = 8'hFF; bus_wr = 1'b1;
    eng_done = 1'b1; eng_err_coll = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_done = 1'b0; eng_err_coll = 1'b0;
    rd(3'd0, v); check("R6 event beats clear", v, 8'h54);
    wr(3'd0, 8'hFF);

    // R7 block port fill, readback and wrap
    wr(3'd1, 8'h80);
    for (int i = 0; i < 32; i++) wr(3'd6, pat(i));
    for (int i = 0; i < 32; i++) begin
      rd(3'd6, v); check("R7 block readback", v, pat(i));
    end
    rd(3'd6, v); check("R7 pointer wrap", v, pat(0));

    // R9 engine view of buffer
    for (int i = 0; i < 32; i += 5) begin
      @(negedge clk); eng_buf_idx = 5'(i);
      #1 check("R9 engine buffer read", eng_buf_rdata, pat(i));
    end

    // R8 buffer clear
    wr(3'd1, 8'hC0);
    for (int i = 0; i < 4; i++) begin
      rd(3'd6, v); check("R8 cleared byte", v, 8'h00);
    end
    rd(3'd1, v); check("R8 clear bit not stored", v, 8'h40);
    // R8 timeout/abort pulses
    wr(3'd1, 8'h0C);
    check("R8 pulses high", {6'd0, timeout_req, abort_req}, 8'h03);
    @(negedge clk);
    check("R8 pulses single", {6'd0, timeout_req, abort_req}, 8'h00);
    rd(3'd1, v); check("R8 request bits not stored", v, 8'h00);
    wr(3'd1, 8'h04);
    check("R8 abort alone", {6'd0, timeout_req, abort_req}, 8'h01);

    // R9 engine loads
    @(negedge clk);
    eng_data_we = 1'b1; eng_data_a = 8'h1F; eng_data_b = 8'hA5;
    @(negedge clk);
    eng_data_we = 1'b0;
    rd(3'd4, v); check("R9 data A load", v, 8'h1F);
    rd(3'd5, v); check("R9 data B load", v, 8'hA5);
    check("R9 data_a port", data_a, 8'h1F);
    check("R9 data_b port", data_b, 8'hA5);
    wr(3'd1, 8'h80);
    @(negedge clk);
    eng_buf_we = 1'b1; eng_buf_idx = 5'd5; eng_buf_wdata = 8'h77;
    @(negedge clk);
    eng_buf_we = 1'b0;
    for (int i = 0; i < 6; i++) begin
      rd(3'd6, v); check("R9 engine buffer write", v, (i == 5) ? 8'h77 : 8'h00);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule